// File: doc/BRIEF.md
# Vector Float Rounding to Integral Value

This block takes a short vector of IEEE-754 single-precision lanes and replaces each active lane's value with an integer-valued number. The result stays in single-precision format. A 3-bit select chooses one of six rounding rules, and it applies to every lane of a transfer. A per-lane active mask lets lanes that are not part of the operation come through bit for bit unchanged. The block is used as a step before a float-to-integer conversion. For example, floor followed by truncation gives integer division. Round-to-odd helps a staged conversion avoid double rounding.

The block has exactly one register stage. A transfer presented with `in_valid` high appears on `out_lanes` one clock later, with `out_valid` high. Exception flags, integer output formats and other float widths are not part of this block.

Top module: `flt_rint_vec`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `out_valid` and `out_lanes` to zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. The results of a transfer appear in that same cycle, and `out_lanes` is captured only when `in_valid` is high.
- R3: A lane whose `in_active` bit is 0 is output bit-identical to its input, whatever the mode.
- R4: Mode code 0 rounds to nearest with ties to even: 1.4→1.0, 2.6→3.0, -1.5→-2.0, 3.0→3.0, 2.5→2.0, 3.5→4.0.
- R5: Mode code 1 rounds half-way and other fractional values away from zero: 2.5→3.0, -2.5→-3.0, 0.5→1.0.
- R6: Mode code 2 rounds toward negative infinity: -2.5→-3.0, -0.4→-1.0, 0.3→+0.0, smallest positive subnormal→+0.0.
- R7: Mode code 3 rounds toward positive infinity: -2.5→-2.0, 7.5→8.0, 0.3→1.0, smallest positive subnormal→1.0.
- R8: Mode code 4 rounds toward zero (truncates): -2.5→-2.0, 2.6→2.0.
- R9: Mode code 5 rounds to odd: a fractional value goes to whichever of its two integer neighbours is odd (2.2→3.0, 3.2→3.0, 0.5→1.0), and integral values are kept (4.0→4.0).
- R10: Mode codes 6 and 7 behave exactly as code 0.
- R11: Inputs with a biased exponent field of 150 or more (magnitude ≥ 2^23, infinities and NaNs) are output unchanged.
- R12: A result of zero magnitude carries the input's sign bit: -0.4 toward zero→-0.0, -0.4 toward +inf→-0.0, and signed zero inputs are kept.
- R13: Every active result is integer-valued and keeps the input's sign bit, including when rounding carries into the next binade (8388607.5 to nearest→8388608.0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Transfer present on the inputs this cycle |
| in_lanes | input | LANES*32 | Packed single-precision lanes, lane 0 in the low bits |
| in_active | input | LANES | Per-lane enable; 0 passes the lane through |
| in_rmode | input | 3 | Rounding select: 0 nearest-even, 1 away, 2 floor, 3 ceil, 4 toward zero, 5 odd, 6/7 nearest-even |
| out_valid | output | 1 | Results valid this cycle |
| out_lanes | output | LANES*32 | Rounded lanes, same packing as `in_lanes` |

## Verification
The hardest case to reach is a round-up that carries out of the 24-bit significand. The exponent must then step up and the mantissa must clear. This only happens when every retained significand bit is already one. The stimulus drives 8388607.5, which has exponent 149 and only one fraction bit, under nearest-even rounding, and also 7.5 under ceil rounding. Signed-zero results and the sub-one-magnitude path are reached with small fractions and a subnormal under each directed mode.

// File: rtl/flt_rint_pkg.sv
// Package: shared constants and the rounding-mode type for the integral
// rounding datapath. Assumes IEEE-754 single-precision layout.
package flt_rint_pkg;
    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int EXP_BIAS = 127;
    localparam int SIG_W    = MAN_W + 1;
    // Biased exponent at and above which a value has no fraction bits.
    localparam int INT_EXP  = EXP_BIAS + MAN_W;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_AWAY      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_ZERO      = 3'd4,
        RM_ODD       = 3'd5
    } rint_mode_e;
endpackage

// File: rtl/flt_rint_mode_dec.sv
// Module: maps the raw 3-bit rounding select onto the mode type.
// Assumes codes 6 and 7 are unused and fold onto nearest-even.
module flt_rint_mode_dec
    import flt_rint_pkg::*;
(
    input  logic [2:0]  code,
    output rint_mode_e  mode
);
    // Decode the select; unused codes fall back to nearest-even.
    always_comb begin
        case (code)
            3'd0:    mode = RM_NEAR_EVEN;
            3'd1:    mode = RM_AWAY;
            3'd2:    mode = RM_DOWN;
            3'd3:    mode = RM_UP;
            3'd4:    mode = RM_ZERO;
            3'd5:    mode = RM_ODD;
            default: mode = RM_NEAR_EVEN;
        endcase
    end

    // R10
    always_comb begin
        spare_code_chk: assert (!(code[2] && code[1]) || mode == RM_NEAR_EVEN)
            else $error("spare rounding code not folded to nearest-even");
    end
endmodule

// File: rtl/flt_rint_lane.sv
// Module: combinational rounding of one single-precision lane to an
// integer-valued single-precision number. It assumes the mode has already
// been decoded. Inactive lanes, large magnitudes, infinities and NaNs pass
// through. A zero-magnitude result keeps the input's sign.
module flt_rint_lane
    import flt_rint_pkg::*;
(
    input  logic [FP_W-1:0] op_in,
    input  logic            active,
    input  rint_mode_e      mode,
    output logic [FP_W-1:0] op_out
);
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic             is_big;
    logic             is_small;
    logic [4:0]       fbits;
    logic [SIG_W-1:0] sig;
    logic [SIG_W-1:0] onebit;
    logic [SIG_W-1:0] fmask;
    logic [SIG_W-1:0] halfv;
    logic [SIG_W-1:0] ipart;
    logic [SIG_W-1:0] fpart;
    logic             any_frac;
    logic             gt_half;
    logic             eq_half;
    logic             int_lsb;
    logic             go_up;
    logic [SIG_W:0]   sum;
    logic [FP_W-1:0]  rounded;

    assign sgn = op_in[FP_W-1];
    assign ex  = op_in[FP_W-2 -: EXP_W];
    assign man = op_in[MAN_W-1:0];

    // Classify magnitude: already integral, below one, or mixed.
    always_comb begin
        is_big   = (ex >= EXP_W'(INT_EXP));
        is_small = (ex <  EXP_W'(EXP_BIAS));
    end

    // Split the significand into integer and fraction parts (mixed range).
    always_comb begin
        fbits  = 5'(EXP_W'(INT_EXP) - ex);
        sig    = {1'b1, man};
        onebit = SIG_W'(1) << fbits;
        fmask  = onebit - SIG_W'(1);
        halfv  = onebit >> 1;
        ipart  = sig & ~fmask;
        fpart  = sig & fmask;
    end

    // Gather the facts the rounding rule needs, for either magnitude range.
    always_comb begin
        if (is_small) begin
            any_frac = (ex != '0) || (man != '0);
            gt_half  = (ex == EXP_W'(EXP_BIAS - 1)) && (man != '0);
            eq_half  = (ex == EXP_W'(EXP_BIAS - 1)) && (man == '0);
            int_lsb  = 1'b0;
        end else begin
            any_frac = (fpart != '0);
            gt_half  = (fpart > halfv);
            eq_half  = (fpart == halfv);
            int_lsb  = (ipart & onebit) != '0;
        end
    end

    // Choose whether the magnitude steps up to the next integer.
    always_comb begin
        case (mode)
            RM_AWAY: go_up = any_frac;
            RM_DOWN: go_up = any_frac & sgn;
            RM_UP:   go_up = any_frac & ~sgn;
            RM_ZERO: go_up = 1'b0;
            RM_ODD:  go_up = any_frac & ~int_lsb;
            default: go_up = gt_half | (eq_half & int_lsb);
        endcase
    end

    // Form the rounded value, bumping the exponent on significand carry.
    always_comb begin
        sum = {1'b0, ipart} + (go_up ? {1'b0, onebit} : '0);
        if (is_big) begin
            rounded = op_in;
        end else if (is_small) begin
            rounded = go_up ? {sgn, EXP_W'(EXP_BIAS), {MAN_W{1'b0}}}
                            : {sgn, {(FP_W-1){1'b0}}};
        end else if (sum[SIG_W]) begin
            rounded = {sgn, ex + EXP_W'(1), {MAN_W{1'b0}}};
        end else begin
            rounded = {sgn, ex, sum[MAN_W-1:0]};
        end
    end

    // Apply the lane mask.
    assign op_out = active ? rounded : op_in;

    // R13
    always_comb begin
        hidden_bit_chk: assert (is_big || is_small || sum[SIG_W] || sum[SIG_W-1])
            else $error("rounded significand lost its leading one");
    end

    // R13
    always_comb begin
        integral_chk: assert (!active || is_big || is_small
                              || (rounded[MAN_W-1:0] & fmask[MAN_W-1:0]) == '0
                              || sum[SIG_W])
            else $error("active result keeps fraction bits");
    end
endmodule

// File: rtl/flt_rint_vec.sv
// Module: top of the vector integral-rounding unit. It decodes the mode once,
// rounds every lane combinationally and registers results plus valid in one
// stage. It assumes one mode per transfer and a synchronous active-low reset.
module flt_rint_vec
    import flt_rint_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*32-1:0]   in_lanes,
    input  logic [LANES-1:0]      in_active,
    input  logic [2:0]            in_rmode,
    output logic                  out_valid,
    output logic [LANES*32-1:0]   out_lanes
);
    localparam int VEC_W = LANES * FP_W;

    rint_mode_e         mode_d;
    logic [VEC_W-1:0]   res_d;
    logic [VEC_W-1:0]   res_q;
    logic               vld_q;

    flt_rint_mode_dec u_dec (
        .code (in_rmode),
        .mode (mode_d)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        flt_rint_lane u_lane (
            .op_in  (in_lanes[g*FP_W +: FP_W]),
            .active (in_active[g]),
            .mode   (mode_d),
            .op_out (res_d[g*FP_W +: FP_W])
        );

        // R3
        inactive_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_active[g]) |=> out_lanes[g*FP_W +: FP_W] == $past(in_lanes[g*FP_W +: FP_W]))
            else $error("inactive lane altered");

        // R11
        big_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_lanes[g*FP_W+FP_W-2 -: EXP_W] >= EXP_W'(INT_EXP))
            |=> out_lanes[g*FP_W +: FP_W] == $past(in_lanes[g*FP_W +: FP_W]))
            else $error("integral or non-finite lane altered");

        // R13
        sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_lanes[g*FP_W+FP_W-1] == $past(in_lanes[g*FP_W+FP_W-1]))
            else $error("lane sign changed");
    end

    // Output register: capture results and valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid = vld_q;
    assign out_lanes = res_q;

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("valid not forwarded");

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_lanes)))
        else $error("output moved without a transfer");
endmodule

// File: tb/flt_rint_vec_tb.sv
module flt_rint_vec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int TIMEOUT    = 20000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [LANES*32-1:0]  in_lanes = '0;
    logic [LANES-1:0]     in_active = '0;
    logic [2:0]           in_rmode = 3'd0;
    logic                 out_valid;
    logic [LANES*32-1:0]  out_lanes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flt_rint_vec #(.LANES(LANES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_lanes  (in_lanes),
        .in_active (in_active),
        .in_rmode  (in_rmode),
        .out_valid (out_valid),
        .out_lanes (out_lanes)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Present one transfer at a falling edge, then sample one cycle later.
    task automatic xfer(input logic [31:0] a0, a1, a2, a3,
                        input logic [3:0] act, input logic [2:0] mode);
        @(negedge clk);
        in_lanes  = {a3, a2, a1, a0};
        in_active = act;
        in_rmode  = mode;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic expect4(input string req, input logic [31:0] e0, e1, e2, e3);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " lane0"}, out_lanes[31:0],   e0);
        chk({req, " lane1"}, out_lanes[63:32],  e1);
        chk({req, " lane2"}, out_lanes[95:64],  e2);
        chk({req, " lane3"}, out_lanes[127:96], e3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 lanes", out_lanes[31:0] | out_lanes[63:32] | out_lanes[95:64] | out_lanes[127:96], 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_near_even();
        xfer(32'h3FB33333, 32'h40266666, 32'hBFC00000, 32'h40400000, 4'hF, 3'd0);
        expect4("R4 a", 32'h3F800000, 32'h40400000, 32'hC0000000, 32'h40400000);
        xfer(32'h40200000, 32'h40600000, 32'h3F000000, 32'h4AFFFFFF, 4'hF, 3'd0);
        expect4("R4 b/R13 carry", 32'h40000000, 32'h40800000, 32'h00000000, 32'h4B000000);
    endtask

    task automatic t_away();
        xfer(32'h40200000, 32'hC0200000, 32'h3F000000, 32'h40400000, 4'hF, 3'd1);
        expect4("R5", 32'h40400000, 32'hC0400000, 32'h3F800000, 32'h40400000);
    endtask

    task automatic t_floor();
        xfer(32'hC0200000, 32'hBECCCCCD, 32'h3E99999A, 32'h00000001, 4'hF, 3'd2);
        expect4("R6", 32'hC0400000, 32'hBF800000, 32'h00000000, 32'h00000000);
    endtask

    task automatic t_ceil();
        xfer(32'hC0200000, 32'h40F00000, 32'h3E99999A, 32'h00000001, 4'hF, 3'd3);
        expect4("R7", 32'hC0000000, 32'h41000000, 32'h3F800000, 32'h3F800000);
    endtask

    task automatic t_zero();
        xfer(32'hC0200000, 32'h40266666, 32'hBECCCCCD, 32'h80000000, 4'hF, 3'd4);
        expect4("R8/R12", 32'hC0000000, 32'h40000000, 32'h80000000, 32'h80000000);
    endtask

    task automatic t_ceil_negzero();
        xfer(32'hBECCCCCD, 32'h80000000, 32'h00000000, 32'hBE99999A, 4'hF, 3'd3);
        expect4("R12", 32'h80000000, 32'h80000000, 32'h00000000, 32'h80000000);
    endtask

    task automatic t_odd();
        xfer(32'h400CCCCD, 32'h404CCCCD, 32'h3F000000, 32'h40800000, 4'hF, 3'd5);
        expect4("R9", 32'h40400000, 32'h40400000, 32'h3F800000, 32'h40800000);
        xfer(32'h40600000, 32'hC0200000, 32'hBECCCCCD, 32'h40A00000, 4'hF, 3'd5);
        expect4("R9 b", 32'h40400000, 32'hC0400000, 32'hBF800000, 32'h40A00000);
    endtask

    task automatic t_spare_codes();
        xfer(32'h40200000, 32'h3FB33333, 32'h40600000, 32'h40266666, 4'hF, 3'd6);
        expect4("R10 code6", 32'h40000000, 32'h3F800000, 32'h40800000, 32'h40400000);
        xfer(32'h40200000, 32'hBFC00000, 32'h3F000000, 32'h4AFFFFFF, 4'hF, 3'd7);
        expect4("R10 code7", 32'h40000000, 32'hC0000000, 32'h00000000, 32'h4B000000);
    endtask

    task automatic t_large();
        xfer(32'h4B000000, 32'h4B000001, 32'h7FC00001, 32'hFF800000, 4'hF, 3'd1);
        expect4("R11", 32'h4B000000, 32'h4B000001, 32'h7FC00001, 32'hFF800000);
    endtask

    task automatic t_inactive();
        xfer(32'h3FB33333, 32'h40266666, 32'hBECCCCCD, 32'h40F00000, 4'b0101, 3'd3);
        expect4("R3", 32'h40000000, 32'h40266666, 32'h80000000, 32'h40F00000);
    endtask

    task automatic t_idle();
        // Transfer, then an idle cycle: valid drops, data holds.
        xfer(32'h40200000, 32'h40200000, 32'h40200000, 32'h40200000, 4'hF, 3'd4);
        @(negedge clk);
        chk("R2 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R2 hold", out_lanes[31:0], 32'h40000000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_near_even();
        t_away();
        t_floor();
        t_ceil();
        t_zero();
        t_ceil_negzero();
        t_odd();
        t_spare_codes();
        t_large();
        t_inactive();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule